// File: doc/BRIEF.md
# Predicate Mask Mapper

This block maps a register named by an operation onto a predicate mask. Configuration is held in a small bank of key/value entries. Each entry says which table it belongs to (integer or floating-point operations) and which register it keys on. It also names the integer register that holds the mask, and carries an invert flag and a zeroing flag.

When a rebuild is triggered, the bank is expanded into two direct-lookup slot tables, one per operation class, with one slot per register. The expansion takes one cycle per entry. After that, a lookup is a single combinational step: select the slot, read the integer register file, and invert the result if the slot asks for it.

A configuration write makes the tables stale. From then on the block raises a stall until a full rebuild has run. The decoder that issues configuration writes and the register file itself sit outside the block. The register file is reached through an address output and an asynchronous data input.

Top module: `pred_map_unit`

## Requirements
- R1: After reset `lk_stall` is 0, every lookup in either table returns an all-ones mask, and `lk_zero` is 0.
- R2: A configuration write (`cfg_we`) raises `lk_stall` from the next cycle. The stall stays high, however long it takes, until a rebuild has been started and has completed.
- R3: A rebuild first disables every slot of both tables. A slot filled by an earlier rebuild reads as disabled if no entry names it any more.
- R4: During a rebuild, an enabled entry fills only the table chosen by its type bit (`cfg_fp`: 0 selects the integer table, 1 the floating-point table), at the slot given by its key. The other table's slot with the same number stays disabled.
- R5: A lookup of a disabled slot returns an all-ones mask.
- R6: A lookup of an enabled slot drives `rf_addr` with the entry's value field. With invert clear, `lk_mask` equals `rf_data`. The mask always comes from the integer register file, for both tables.
- R7: When the slot's invert flag is set, `lk_mask` is the bitwise complement of `rf_data`.
- R8: `lk_zero` equals the slot's zeroing flag when the slot is enabled, and is 0 otherwise.
- R9: Entries are applied in ascending index order, so the highest-indexed enabled entry with a given type and key decides the slot.
- R10: A rebuild pulse sampled at clock edge T clears the tables at T and applies entry k at edge T+1+k. `lk_stall` is high for the N_ENTRY cycles after T and low after edge T+N_ENTRY, when no write intervened.
- R11: An entry whose enable bit (`cfg_en`) is 0 is skipped by the rebuild and fills no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_idx | input | ENT_W (4) | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_fp | input | 1 | Table select: 0 integer, 1 floating-point |
| cfg_key | input | REG_W (5) | Register keyed by the entry |
| cfg_src | input | REG_W (5) | Integer register holding the mask |
| cfg_inv | input | 1 | Invert the mask |
| cfg_zero | input | 1 | Zeroing flag passed to the lookup |
| rebuild | input | 1 | Start expanding the entries into the tables |
| lk_fp | input | 1 | Lookup table select |
| lk_reg | input | REG_W (5) | Register being looked up |
| lk_stall | output | 1 | Tables stale or being rebuilt |
| lk_mask | output | XLEN (32) | Effective predicate mask |
| lk_zero | output | 1 | Zeroing flag of the looked-up slot |
| rf_addr | output | REG_W (5) | Integer register file read address |
| rf_data | input | XLEN (32) | Integer register file read data |

## Verification
The assertions assume two things about the inputs. First, `rf_data` answers `rf_addr` in the same cycle. Second, a `rebuild` pulse that arrives while a fill is running is ignored rather than queued. The stimulus therefore models the register file as a combinational array of fixed, distinct values. It issues rebuild pulses only while the block is idle, and it makes lookups only while `lk_stall` is low, which is the only time the slot contents are defined by the configuration.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_FILL = 1'b1
   } seq_state_e;

   localparam int TBL_COUNT = 2;   // integer table, floating-point table
endpackage

// File: rtl/pmu_cfg_store.sv
`timescale 1ns/1ps
module pmu_cfg_store #(
   parameter int N_ENTRY  = 16,
   parameter int ENT_W    = 4,
   parameter int ENT_BITS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ENT_W-1:0]    wr_idx,
   input  logic [ENT_BITS-1:0] wr_data,
   input  logic [ENT_W-1:0]    rd_idx,
   output logic [ENT_BITS-1:0] rd_data
);
   logic [ENT_BITS-1:0] bank [N_ENTRY];

   for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[e] <= '0;
         else if (wr_en && wr_idx == ENT_W'(e))
            bank[e] <= wr_data;
      end
   end

   assign rd_data = bank[rd_idx];
endmodule

// File: rtl/pmu_seq.sv
`timescale 1ns/1ps
module pmu_seq #(
   parameter int N_ENTRY = 16,
   parameter int ENT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             rebuild,
   output logic             clear,
   output logic             apply,
   output logic [ENT_W-1:0] ptr,
   output logic             stall
);
   import pmu_pkg::*;

   localparam logic [ENT_W-1:0] LAST = ENT_W'(N_ENTRY - 1);

   seq_state_e state;
   logic       pending;

   assign clear = (state == SEQ_IDLE) && rebuild;
   assign apply = (state == SEQ_FILL);
   assign stall = pending || (state == SEQ_FILL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         ptr     <= '0;
         pending <= 1'b0;
      end else begin
         if (state == SEQ_IDLE) begin
            if (rebuild) begin
               state <= SEQ_FILL;
               ptr   <= '0;
            end
         end else begin
            if (ptr == LAST) begin
               state <= SEQ_IDLE;
               ptr   <= '0;
            end else begin
               ptr <= ptr + 1'b1;
            end
         end
         if (cfg_we)
            pending <= 1'b1;
         else if (clear)
            pending <= 1'b0;
      end
   end

   // R2: a configuration write is followed by a stall
   a_r2_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> stall);

   // R10: a fill starts at entry 0 right after the clearing edge
   a_r10_fill_starts: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (apply && ptr == '0));

   // R10: the fill ends after the last entry
   a_r10_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && ptr == LAST) |=> !apply);
endmodule

// File: rtl/pmu_slot_tbl.sv
`timescale 1ns/1ps
module pmu_slot_tbl #(
   parameter int N_REG = 32,
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_key,
   input  logic [REG_W-1:0] wr_src,
   input  logic             wr_inv,
   input  logic             wr_zero,
   input  logic [REG_W-1:0] rd_key,
   output logic             rd_on,
   output logic [REG_W-1:0] rd_src,
   output logic             rd_inv,
   output logic             rd_zero
);
   logic [N_REG-1:0] on_vec;
   logic [REG_W-1:0] src_q  [N_REG];
   logic             inv_q  [N_REG];
   logic             zero_q [N_REG];

   for (genvar s = 0; s < N_REG; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_key == REG_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n || clear)
            on_vec[s] <= 1'b0;
         else if (hit)
            on_vec[s] <= 1'b1;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q[s]  <= '0;
            inv_q[s]  <= 1'b0;
            zero_q[s] <= 1'b0;
         end else if (hit) begin
            src_q[s]  <= wr_src;
            inv_q[s]  <= wr_inv;
            zero_q[s] <= wr_zero;
         end
      end
   end

   assign rd_on   = on_vec[rd_key];
   assign rd_src  = src_q[rd_key];
   assign rd_inv  = inv_q[rd_key];
   assign rd_zero = zero_q[rd_key];

   // R3: a clear leaves no slot enabled
   a_r3_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ($countones(on_vec) == 0));

   // R4: a written slot is enabled on the next cycle
   a_r4_slot_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear) |=> on_vec[$past(wr_key)]);
endmodule

// File: rtl/pred_map_unit.sv
`timescale 1ns/1ps
module pred_map_unit #(
   parameter int N_ENTRY = 16,
   parameter int N_REG   = 32,
   parameter int XLEN    = 32,
   localparam int ENT_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
   localparam int REG_W  = $clog2(N_REG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [ENT_W-1:0] cfg_idx,
   input  logic             cfg_en,
   input  logic             cfg_fp,
   input  logic [REG_W-1:0] cfg_key,
   input  logic [REG_W-1:0] cfg_src,
   input  logic             cfg_inv,
   input  logic             cfg_zero,
   input  logic             rebuild,
   input  logic             lk_fp,
   input  logic [REG_W-1:0] lk_reg,
   output logic             lk_stall,
   output logic [XLEN-1:0]  lk_mask,
   output logic             lk_zero,
   output logic [REG_W-1:0] rf_addr,
   input  logic [XLEN-1:0]  rf_data
);
   import pmu_pkg::*;

   localparam int ENT_BITS = 4 + 2 * REG_W;

   if (N_REG < 2 || (1 << REG_W) != N_REG) begin : g_bad_nreg
      $error("N_REG must be a power of two, at least 2");
   end
   if (N_ENTRY < 1) begin : g_bad_nent
      $error("N_ENTRY must be at least 1");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("XLEN must be at least 1");
   end

   logic [ENT_BITS-1:0] wr_word, ent;
   logic                clear, apply;
   logic [ENT_W-1:0]    ptr;

   assign wr_word = {cfg_en, cfg_fp, cfg_key, cfg_src, cfg_inv, cfg_zero};

   pmu_cfg_store #(.N_ENTRY(N_ENTRY), .ENT_W(ENT_W), .ENT_BITS(ENT_BITS)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
      .wr_data(wr_word), .rd_idx(ptr), .rd_data(ent));

   pmu_seq #(.N_ENTRY(N_ENTRY), .ENT_W(ENT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rebuild(rebuild),
      .clear(clear), .apply(apply), .ptr(ptr), .stall(lk_stall));

   logic             e_en, e_fp, e_inv, e_zero;
   logic [REG_W-1:0] e_key, e_src;
   assign {e_en, e_fp, e_key, e_src, e_inv, e_zero} = ent;

   logic             t_on   [TBL_COUNT];
   logic [REG_W-1:0] t_src  [TBL_COUNT];
   logic             t_inv  [TBL_COUNT];
   logic             t_zero [TBL_COUNT];

   for (genvar t = 0; t < TBL_COUNT; t++) begin : g_tbl
      pmu_slot_tbl #(.N_REG(N_REG), .REG_W(REG_W)) u_tbl (
         .clk(clk), .rst_n(rst_n), .clear(clear),
         .wr_en(apply && e_en && (e_fp == 1'(t))),
         .wr_key(e_key), .wr_src(e_src), .wr_inv(e_inv), .wr_zero(e_zero),
         .rd_key(lk_reg), .rd_on(t_on[t]), .rd_src(t_src[t]),
         .rd_inv(t_inv[t]), .rd_zero(t_zero[t]));
   end

   logic sel_on, sel_inv, sel_zero;
   assign sel_on   = t_on[lk_fp];
   assign sel_inv  = t_inv[lk_fp];
   assign sel_zero = t_zero[lk_fp];
   assign rf_addr  = t_src[lk_fp];

   always_comb begin
      if (!sel_on)
         lk_mask = '1;
      else if (sel_inv)
         lk_mask = ~rf_data;
      else
         lk_mask = rf_data;
   end
   assign lk_zero = sel_on && sel_zero;

   // R2: an idle block only starts stalling on a write (no rebuild requested)
   a_r2_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_stall && !rebuild) |=> (lk_stall == $past(cfg_we)));
endmodule

// File: tb/sim_pred_map_unit.sv
`timescale 1ns/1ps
module sim_pred_map_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic        cfg_en = 1'b0, cfg_fp = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0;
   logic [4:0]  cfg_key = '0, cfg_src = '0;
   logic        rebuild = 1'b0;
   logic        lk_fp = 1'b0;
   logic [4:0]  lk_reg = '0;
   logic        lk_req = 1'b0;
   logic        lk_stall, lk_zero;
   logic [31:0] lk_mask, rf_data;
   logic [4:0]  rf_addr;

   logic [31:0] rf [32];
   assign rf_data = rf[rf_addr];

   always #2.5 clk = ~clk;

   pred_map_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_en(cfg_en), .cfg_fp(cfg_fp), .cfg_key(cfg_key), .cfg_src(cfg_src),
      .cfg_inv(cfg_inv), .cfg_zero(cfg_zero), .rebuild(rebuild),
      .lk_fp(lk_fp), .lk_reg(lk_reg), .lk_stall(lk_stall),
      .lk_mask(lk_mask), .lk_zero(lk_zero), .rf_addr(rf_addr),
      .rf_data(rf_data));

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // bench model of the configuration bank
   bit         m_en [16];
   bit         m_fp [16];
   bit [4:0]   m_key [16];
   bit [4:0]   m_src [16];
   bit         m_inv [16];
   bit         m_zero [16];

   // scoreboard queues
   logic [31:0] q_mask [$];
   logic        q_zero [$];
   string       q_tag  [$];

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int idx, input bit en, input bit fp,
                            input bit [4:0] key, input bit [4:0] src,
                            input bit inv, input bit zero);
      m_en[idx] = en; m_fp[idx] = fp; m_key[idx] = key;
      m_src[idx] = src; m_inv[idx] = inv; m_zero[idx] = zero;
      cfg_idx = 4'(idx); cfg_en = en; cfg_fp = fp; cfg_key = key;
      cfg_src = src; cfg_inv = inv; cfg_zero = zero; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // driver: compute expectation from the model, push it, issue lookup
   task automatic look(input bit fp, input bit [4:0] r, input string tag);
      bit found = 1'b0;
      bit [4:0] src = '0;
      bit inv = 1'b0, zero = 1'b0;
      logic [31:0] exp;
      for (int i = 0; i < 16; i++) begin
         if (m_en[i] && m_fp[i] == fp && m_key[i] == r) begin
            found = 1'b1; src = m_src[i]; inv = m_inv[i]; zero = m_zero[i];
         end
      end
      exp = !found ? 32'hFFFF_FFFF : (inv ? ~rf[src] : rf[src]);
      q_mask.push_back(exp);
      q_zero.push_back(found & zero);
      q_tag.push_back(tag);
      lk_fp = fp; lk_reg = r; lk_req = 1'b1;
      @(posedge clk); #1;
      lk_req = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (lk_req && q_mask.size() > 0) begin
         logic [31:0] em;
         logic        ez;
         string       tg;
         em = q_mask.pop_front();
         ez = q_zero.pop_front();
         tg = q_tag.pop_front();
         chk(lk_mask === em, {tg, " mask"}, lk_mask, em);
         chk(lk_zero === ez, {tg, " zero R8"}, 32'(lk_zero), 32'(ez));
      end
   end

   // R10: stall high for 16 cycles after the rebuild edge, low after
   task automatic rebuild_timed(input string tag);
      int highs = 0;
      bit last_low;
      rebuild = 1'b1;
      @(posedge clk); #1;
      rebuild = 1'b0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (lk_stall) highs++;
      end
      @(negedge clk);
      last_low = !lk_stall;
      chk(highs == 16, {tag, " R10 stall cycles"}, 32'(highs), 32'd16);
      chk(last_low, {tag, " R10 stall released"}, 32'(!last_low), 32'd0);
      @(posedge clk); #1;
   endtask

   initial begin
      for (int i = 0; i < 32; i++)
         rf[i] = (32'(i) + 32'd1) * 32'h9E37_79B9;
      for (int i = 0; i < 16; i++) begin
         m_en[i] = 0; m_fp[i] = 0; m_key[i] = 0;
         m_src[i] = 0; m_inv[i] = 0; m_zero[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 / R5: reset state
      chk(lk_stall == 1'b0, "R1 stall after reset", 32'(lk_stall), 32'd0);
      look(1'b0, 5'd3, "R1 int lookup");
      look(1'b1, 5'd7, "R5 fp lookup");
      look(1'b1, 5'd31, "R5 fp top reg");

      // first configuration
      cfg_write(0, 1, 0, 5'd4, 5'd10, 0, 1);
      chk(lk_stall == 1'b1, "R2 stall after write", 32'(lk_stall), 32'd1);
      cfg_write(1, 1, 1, 5'd4, 5'd11, 1, 0);
      cfg_write(2, 1, 0, 5'd9, 5'd12, 0, 1);
      cfg_write(3, 1, 0, 5'd4, 5'd13, 1, 0);
      cfg_write(5, 0, 0, 5'd20, 5'd14, 0, 1);
      rebuild_timed("first");
      look(1'b0, 5'd4, "R9 R7 override int4");
      look(1'b1, 5'd4, "R4 R6 R7 fp4 from int rf");
      look(1'b0, 5'd9, "R6 R8 int9");
      look(1'b0, 5'd20, "R11 skipped entry");
      look(1'b1, 5'd9, "R4 other table");

      // stall holds while pending, stale slot cleared
      cfg_write(2, 0, 0, 5'd9, 5'd12, 0, 1);
      repeat (5) @(posedge clk);
      #1;
      chk(lk_stall == 1'b1, "R2 stall held while pending", 32'(lk_stall), 32'd1);
      rebuild_timed("second");
      look(1'b0, 5'd9, "R3 stale slot cleared");
      look(1'b0, 5'd4, "R9 still overridden");

      // removing the overriding entry exposes the earlier one
      cfg_write(3, 0, 0, 5'd4, 5'd13, 1, 0);
      rebuild_timed("third");
      look(1'b0, 5'd4, "R9 earlier entry");

      // register-number boundaries
      cfg_write(15, 1, 1, 5'd31, 5'd0, 1, 1);
      cfg_write(6, 1, 0, 5'd0, 5'd31, 0, 0);
      rebuild_timed("fourth");
      look(1'b1, 5'd31, "R7 fp31 inverted");
      look(1'b0, 5'd0, "R6 int0");
      look(1'b1, 5'd0, "R4 fp0 untouched");
      look(1'b0, 5'd31, "R5 int31 off");

      @(posedge clk); #1;
      chk(q_mask.size() == 0, "scoreboard drained", 32'(q_mask.size()), 32'd0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule